// File: doc/BRIEF.md
# Serial Bit-Addressed I/O Port Controller

This block is the processor-side engine for an I/O bus that is one bit wide and addressed bit by bit. A device occupies a range of bit addresses. Software names the start of that range with a base value held in workspace register 12. The controller turns one command into bus transfers, and each transfer carries exactly one bit at one bit address.

Three single-bit commands exist: drive a one, drive a zero, and sample an input bit. Each of them adds a signed 8-bit displacement to the base. A fourth command serialises a field of up to a full word. It starts at the base address and steps the address by one for each bit, with one strobe per bit. That is how a character or a control word reaches a device.

The command port has no handshake. A command is taken only while the controller is not driving a bus cycle. The sampled bit comes back as an equality flag, and a one-cycle `done` marks the end of every command.

Top module: `bitio_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `bus_strobe`, `done` and `test_eq` are low.
- R2: A command with `cmd_op` = 2'b00 (drive one), taken at an edge, gives in the next cycle exactly one strobe with `bus_dout` = 1 and `done` high in that same cycle.
- R3: A command with `cmd_op` = 2'b01 (drive zero) behaves like R2 but with `bus_dout` = 0.
- R4: For single-bit commands, `bus_addr` = `cmd_base[12:1]` + sign-extended `cmd_disp`, taken modulo 4096, so negative displacements and wrap-around both work.
- R5: A command with `cmd_op` = 2'b10 (test) puts the address on the bus for one cycle without a strobe. `bus_din` is sampled at the end of that cycle, and the sampled value appears on `test_eq` in the following cycle together with `done`. `test_eq` keeps that value until the next test finishes.
- R6: A command with `cmd_op` = 2'b11 (shift out) takes its bit count n from `cmd_disp[3:0]`. It gives n strobes on consecutive cycles at addresses `cmd_base[12:1]`, +1, +2 and so on, modulo 4096. The displacement is not added. `done` goes high on the last strobe.
- R7: For a count of 1 to 8, the shifted bits are `cmd_data[8]` upwards, least significant first. For a count of 9 to 15, they are `cmd_data[0]` upwards.
- R8: A count field of 0 shifts all 16 bits of `cmd_data`, starting with bit 0.
- R9: A command presented while a strobe is being driven, or during the address cycle of a test, is ignored. The bus sequence then in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Command code (see R2, R3, R5, R6) |
| cmd_base | input | 16 | Base register value; bits 12:1 form the base bit address |
| cmd_disp | input | 8 | Signed displacement, or the bit count in bits 3:0 for shift out |
| cmd_data | input | 16 | Source word for shift out |
| bus_addr | output | 12 | Bit address of the current transfer |
| bus_dout | output | 1 | Output bit value |
| bus_strobe | output | 1 | Write strobe, one per output bit |
| bus_din | input | 1 | Input bit from the addressed device |
| test_eq | output | 1 | Result of the last test command |
| done | output | 1 | One-cycle pulse at the end of each command |

## Verification
Directed commands first separate the two drive polarities, positive from negative displacements, and wrapped from unwrapped addresses. Shift counts of 1, 3, 8, 9, 15 and 0 use a source word with different upper and lower bytes, so a wrong byte choice or a reversed bit order shows up on `bus_dout`. Back-to-back and random command streams then fall on busy cycles and on the exact cycle where the controller becomes free, which tells the ignore rule apart from an off-by-one in the acceptance window. A random `bus_din` shows whether the test result comes from the right cycle.

// File: rtl/bitio_ctrl.sv
module bitio_ctrl #(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_base,
  input  logic [DISP_W-1:0] cmd_disp,
  input  logic [WORD_W-1:0] cmd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_dout,
  output logic              bus_strobe,
  input  logic              bus_din,
  output logic              test_eq,
  output logic              done
);
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int LEFT_W = CNT_W + 1;
  localparam int HALF   = WORD_W / 2;
  localparam logic [LEFT_W-1:0] HALF_L = LEFT_W'(HALF);
  localparam logic [LEFT_W-1:0] FULL_L = LEFT_W'(WORD_W);
  localparam logic [LEFT_W-1:0] ONE_L  = LEFT_W'(1);

  localparam logic [1:0] OP_SET1  = 2'b00;
  localparam logic [1:0] OP_SET0  = 2'b01;
  localparam logic [1:0] OP_TEST  = 2'b10;
  localparam logic [1:0] OP_SHIFT = 2'b11;

  logic [ADDR_W-1:0] addr_q;
  logic              dout_q, strobe_q, probe_q, eq_q, eqdone_q;
  logic [WORD_W-1:0] shreg_q;
  logic [LEFT_W-1:0] left_q;

  logic busy, accept, last;
  assign busy   = strobe_q | probe_q;
  assign accept = cmd_valid & ~busy;
  assign last   = left_q == ONE_L;

  logic [ADDR_W-1:0] base_addr, eff_addr;
  assign base_addr = cmd_base[ADDR_W:1];
  assign eff_addr  = base_addr + {{(ADDR_W-DISP_W){cmd_disp[DISP_W-1]}}, cmd_disp};

  logic [CNT_W-1:0]  cnt_field;
  logic [LEFT_W-1:0] nbits;
  logic [WORD_W-1:0] src;
  assign cnt_field = cmd_disp[CNT_W-1:0];
  assign nbits     = (cnt_field == '0) ? FULL_L : {1'b0, cnt_field};
  assign src       = (nbits <= HALF_L) ? (cmd_data >> HALF) : cmd_data;

  wire unused_bits = ^{cmd_base[0], cmd_base[WORD_W-1:ADDR_W+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      dout_q   <= 1'b0;
      strobe_q <= 1'b0;
      probe_q  <= 1'b0;
      eq_q     <= 1'b0;
      eqdone_q <= 1'b0;
      shreg_q  <= '0;
      left_q   <= '0;
    end else begin
      eqdone_q <= probe_q;
      probe_q  <= 1'b0;
      if (probe_q) eq_q <= bus_din;
      if (strobe_q) begin
        if (!last) begin
          addr_q  <= addr_q + ADDR_W'(1);
          dout_q  <= shreg_q[0];
          shreg_q <= shreg_q >> 1;
          left_q  <= left_q - ONE_L;
        end else begin
          strobe_q <= 1'b0;
        end
      end
      if (accept) begin
        case (cmd_op)
          OP_SET1, OP_SET0: begin
            addr_q   <= eff_addr;
            dout_q   <= (cmd_op == OP_SET1);
            strobe_q <= 1'b1;
            left_q   <= ONE_L;
          end
          OP_TEST: begin
            addr_q  <= eff_addr;
            probe_q <= 1'b1;
          end
          default: begin
            addr_q   <= base_addr;
            dout_q   <= src[0];
            shreg_q  <= src >> 1;
            left_q   <= nbits;
            strobe_q <= 1'b1;
          end
        endcase
      end
    end
  end

  assign bus_addr   = addr_q;
  assign bus_dout   = dout_q;
  assign bus_strobe = strobe_q;
  assign test_eq    = eq_q;
  assign done       = (strobe_q & last) | eqdone_q;
endmodule

// File: rtl/bitio_ctrl_chk.sv
module bitio_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16,
  parameter int DISP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [WORD_W-1:0] cmd_base,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_dout,
  input logic              bus_strobe,
  input logic              test_eq,
  input logic              done,
  input logic              busy
);
  AST_SET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && !cmd_op[1]) |=> (bus_strobe && done && bus_dout == !$past(cmd_op[0]))); // R2
  AST_TEST_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 2'b10) |=> (!bus_strobe && !done)); // R5
  AST_EQ_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(test_eq) |-> done); // R5
  AST_SHIFT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 2'b11) |=> (bus_strobe && bus_addr == $past(cmd_base[ADDR_W:1]))); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && !done) |=> (bus_strobe && bus_addr == $past(bus_addr) + ADDR_W'(1))); // R6
  AST_LAST_STROBE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && done) |=> !bus_strobe); // R9
endmodule

bind bitio_ctrl bitio_ctrl_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .DISP_W(DISP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_base(cmd_base),
  .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_strobe(bus_strobe), .test_eq(test_eq),
  .done(done), .busy(busy)
);

// File: tb/bitio_ctrl_test.sv
`timescale 1ns/1ps
module bitio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [15:0] cmd_base = 16'h0;
  logic [7:0]  cmd_disp = 8'h0;
  logic [15:0] cmd_data = 16'h0;
  logic [11:0] bus_addr;
  logic        bus_dout, bus_strobe, test_eq, done;
  logic        bus_din = 1'b0;

  bitio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_base(cmd_base),
    .cmd_disp(cmd_disp), .cmd_data(cmd_data), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_strobe(bus_strobe), .bus_din(bus_din), .test_eq(test_eq), .done(done)
  );

  always #2.5 clk = ~clk;

  int    n_checks = 0;
  int    n_fails = 0;
  string phase = "R1 reset";

  typedef struct { int addr; bit b; bit last; } beat_t;
  beat_t pend[$];
  beat_t cur;
  bit    cur_v = 0, probe = 0, eq = 0, eqdone = 0;

  // Behavioural reference: a queue of bus beats per command, advanced once per clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend.delete();
      cur_v = 0; probe = 0; eq = 0; eqdone = 0;
    end else begin
      bit busy_m;
      busy_m = cur_v || probe;
      eqdone = probe;
      if (probe) eq = bus_din;
      probe = 0;
      if (!busy_m && cmd_valid) begin
        int b, d, n;
        b = int'(cmd_base) / 2;
        d = int'($signed(cmd_disp));
        case (cmd_op)
          2'b00: pend.push_back('{(b + d) & 4095, 1'b1, 1'b1});
          2'b01: pend.push_back('{(b + d) & 4095, 1'b0, 1'b1});
          2'b10: probe = 1;
          default: begin
            n = (cmd_disp[3:0] == 0) ? 16 : int'(cmd_disp[3:0]);
            for (int i = 0; i < n; i++)
              pend.push_back('{(b + i) & 4095, (n <= 8) ? cmd_data[8 + i] : cmd_data[i], i == n - 1});
          end
        endcase
      end
      if (pend.size() > 0) begin cur = pend.pop_front(); cur_v = 1; end
      else cur_v = 0;
    end
  end

  task automatic chk(string what, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fails++;
      $display("FAIL %s %s: got %0d expected %0d", phase, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("strobe (R6)", int'(bus_strobe), int'(cur_v));
    chk("done (R2)", int'(done), int'((cur_v && cur.last) || eqdone));
    chk("test_eq (R5)", int'(test_eq), int'(eq));
    if (cur_v) begin
      chk("addr (R4)", int'(bus_addr), cur.addr);
      chk("dout (R7)", int'(bus_dout), int'(cur.b));
    end
  end

  always @(negedge clk) bus_din <= 1'($urandom_range(0, 1));

  task automatic drive(logic [1:0] op, logic [15:0] base, logic [7:0] disp, logic [15:0] data);
    cmd_valid = 1'b1; cmd_op = op; cmd_base = base; cmd_disp = disp; cmd_data = data;
    @(negedge clk);
  endtask

  task automatic issue(logic [1:0] op, logic [15:0] base, logic [7:0] disp, logic [15:0] data, int gap);
    drive(op, base, disp, data);
    cmd_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: got 0 expected 1 (run completed)");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    phase = "R2 drive one";
    issue(2'b00, 16'h0040, 8'h03, 16'h0, 3);
    issue(2'b00, 16'h1FFE, 8'h01, 16'h0, 3);     // wraps to address 0 (R4)
    phase = "R3 drive zero";
    issue(2'b01, 16'h0100, 8'h05, 16'h0, 3);
    phase = "R4 negative displacement";
    issue(2'b00, 16'h0010, 8'hF0, 16'h0, 3);
    issue(2'b01, 16'h0000, 8'h80, 16'h0, 3);
    phase = "R5 test bit";
    for (int i = 0; i < 8; i++) issue(2'b10, 16'h0200, 8'(i), 16'h0, 1 + i % 3);
    phase = "R7 short shift";
    issue(2'b11, 16'h0300, 8'h08, 16'hA53C, 10);
    issue(2'b11, 16'h0300, 8'h01, 16'h80FF, 3);
    issue(2'b11, 16'h0300, 8'hF3, 16'h5A00, 5);
    phase = "R6 wide shift";
    issue(2'b11, 16'h1FF8, 8'h09, 16'hC3A5, 12);
    issue(2'b11, 16'h0020, 8'h0F, 16'h6DB1, 18);
    phase = "R8 count zero";
    issue(2'b11, 16'h0400, 8'h00, 16'hB7E2, 20);
    phase = "R9 overlapping commands";
    drive(2'b11, 16'h0500, 8'h04, 16'hFF00);
    drive(2'b00, 16'h0600, 8'h01, 16'h0);
    drive(2'b01, 16'h0700, 8'h02, 16'h0);
    issue(2'b10, 16'h0800, 8'h00, 16'h0, 0);
    drive(2'b10, 16'h0800, 8'h01, 16'h0);
    drive(2'b00, 16'h0900, 8'h01, 16'h0);
    issue(2'b00, 16'h0A00, 8'h01, 16'h0, 20);
    phase = "R9 random stream";
    for (int i = 0; i < 3000; i++) begin
      cmd_valid = 1'($urandom_range(0, 2) != 0);
      cmd_op    = 2'($urandom_range(0, 3));
      cmd_base  = 16'($urandom);
      cmd_disp  = 8'($urandom);
      cmd_data  = 16'($urandom);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    repeat (20) @(negedge clk);
    finish_up();
  end
endmodule